// File: doc/BRIEF.md
# NAND Read Prefetch Engine

This block pulls a programmed number of bytes from a NAND flash data port, one byte per handshake, and stores them in an internal byte-counted FIFO. A host processor drains the FIFO one 32-bit word at a time. Software sets the engine up through four word registers: a run register, a setup register (direction, enable, fill threshold, chip select), a length register and a read-only progress register. It then starts the engine and drains words as they become available.

The engine stops asking the flash for bytes when its FIFO is full or when the programmed length has been fetched. It delivers a word to the host only once the FIFO holds at least the programmed threshold, or once fetching is finished. When the last word has been drained, the engine drops its busy bit without help from software. Writing zero to the run register or to the setup register aborts the transfer and flushes the FIFO.

Top module: `nand_prefetch_engine`

## Requirements
- R1: After reset, the run register (address 0) reads 0, the progress register (address 3) reads 0, `nand_rd_req` is low and `word_avail` is low.
- R2: Register address 1 (setup) holds the direction in bit 0 (0 = read prefetch), the enable in bit 7, the fill threshold in bits 14:8 and the chip select in bits 26:24. A write is read back with the other bits at zero, and the chip select field drives `nand_cs`.
- R3: A setup write whose threshold field exceeds 64 is discarded: the setup register keeps its previous value.
- R4: Writing 1 to the run register sets its bit 0 (busy) only when the engine is idle, enable is 1, direction is 0, and the length register (address 2, bits 13:0) is nonzero and a multiple of 4. Otherwise the write is refused. `nand_rd_req` is never high while the engine is idle.
- R5: Writing 1 to the run register while busy is refused: the remaining count is not reloaded.
- R6: The progress register reports the remaining byte count in bits 13:0, which drops by one for each accepted byte (`nand_rd_req` and `nand_rd_ack` high at a clock edge), and the FIFO byte occupancy in bits 30:24.
- R7: The engine requests bytes only while busy, with a remaining count above zero and fewer than 64 bytes held. The FIFO never holds more than 64 bytes.
- R8: Bytes are packed little-endian, so the first byte received in each group of four lands in bits 7:0 of `word_data`.
- R9: `word_avail` is high only when at least 4 bytes are held and either the occupancy reaches the threshold or the remaining count is zero. A `word_pop` while `word_avail` is low has no effect.
- R10: Once the remaining count and the occupancy are both zero, the busy bit clears on the next clock edge.
- R11: Writing 0 to the run register or to the setup register stops the engine: busy, remaining count and occupancy all become 0. A zero setup write also clears the setup register.
- R12: While busy, nonzero writes to the setup and length registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 run, 1 setup, 2 length, 3 progress |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` (combinational) |
| word_avail | output | 1 | A word may be popped |
| word_pop | input | 1 | Host pops the head word |
| word_data | output | 32 | Head word of the FIFO |
| nand_cs | output | 3 | Chip select taken from the setup register |
| nand_rd_req | output | 1 | Engine wants a byte from the flash |
| nand_rd_ack | input | 1 | Flash supplies a byte this cycle |
| nand_rd_data | input | 8 | Byte from the flash |

## Verification
If the internal state goes wrong, it shows at the host port within a cycle or two. A slip in the byte packer or a FIFO pointer turns up as a scoreboard mismatch on the very next popped word. An off-by-one in the occupancy tally shows up as `word_avail` rising against the threshold a cycle early or late, or as `nand_rd_req` staying high against a full FIFO. A wrong remaining count shows up as the busy bit failing to clear exactly one cycle after the final pop, or as a refused restart that still changes the progress register.

// File: rtl/nand_pf_pkg.sv
package nand_pf_pkg;
  localparam logic [1:0] A_RUN   = 2'd0;
  localparam logic [1:0] A_SETUP = 2'd1;
  localparam logic [1:0] A_LEN   = 2'd2;
  localparam logic [1:0] A_PROG  = 2'd3;

  localparam int DIR_BIT  = 0;
  localparam int EN_BIT   = 7;
  localparam int THR_LSB  = 8;
  localparam int CS_LSB   = 24;
  localparam int FILL_LSB = 24;
endpackage

// File: rtl/nand_pf_ctrl.sv
module nand_pf_ctrl
  import nand_pf_pkg::*;
#(
  parameter int DEPTH_BYTES = 64,
  parameter int CNT_W       = 14,
  parameter int THR_W       = 7,
  parameter int CS_W        = 3,
  parameter int FILL_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              byte_take,
  input  logic [FILL_W-1:0] fill,
  output logic              busy,
  output logic [CNT_W-1:0]  rem,
  output logic [CNT_W-1:0]  total,
  output logic [THR_W-1:0]  thr,
  output logic [CS_W-1:0]   cs,
  output logic              en,
  output logic              dir,
  output logic              flush
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] rem_q, rem_d, total_q;
  logic [THR_W-1:0] thr_q, thr_in;
  logic [CS_W-1:0]  cs_q;
  logic             en_q, dir_q;
  logic run_wr, setup_wr, len_wr, stop, start, done, thr_ok;
  logic cfg_ld, cfg_clr, len_ld;

  assign run_wr   = wr_en && (wr_addr == A_RUN);
  assign setup_wr = wr_en && (wr_addr == A_SETUP);
  assign len_wr   = wr_en && (wr_addr == A_LEN);
  assign thr_in   = wr_data[THR_LSB +: THR_W];
  assign thr_ok   = (thr_in <= THR_W'(DEPTH_BYTES));
  assign stop     = (run_wr || setup_wr) && (wr_data == '0);
  assign start    = run_wr && (wr_data == 32'd1) && !busy_q && en_q && !dir_q &&
                    (total_q != '0) && (total_q[1:0] == 2'b00);
  assign done     = busy_q && (rem_q == '0) && (fill == '0);
  assign cfg_clr  = setup_wr && stop;
  assign cfg_ld   = setup_wr && !stop && !busy_q && thr_ok;
  assign len_ld   = len_wr && !busy_q;

  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    if (stop || done) busy_d = 1'b0;
    else if (start)   busy_d = 1'b1;
    if (stop)                     rem_d = '0;
    else if (start)               rem_d = total_q;
    else if (byte_take && busy_q) rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rem_q  <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
      cs_q  <= '0;
      en_q  <= 1'b0;
      dir_q <= 1'b0;
    end else if (cfg_clr) begin
      thr_q <= '0;
      cs_q  <= '0;
      en_q  <= 1'b0;
      dir_q <= 1'b0;
    end else if (cfg_ld) begin
      thr_q <= thr_in;
      cs_q  <= wr_data[CS_LSB +: CS_W];
      en_q  <= wr_data[EN_BIT];
      dir_q <= wr_data[DIR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      total_q <= '0;
    else if (len_ld) total_q <= wr_data[CNT_W-1:0];
  end

  assign busy  = busy_q;
  assign rem   = rem_q;
  assign total = total_q;
  assign thr   = thr_q;
  assign cs    = cs_q;
  assign en    = en_q;
  assign dir   = dir_q;
  assign flush = stop;

  assert_thr_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q <= THR_W'(DEPTH_BYTES));

  assert_no_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> (rem_q == $past(rem_q)) || (rem_q == $past(rem_q) - 1'b1));

  assert_auto_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_q) && ($past(rem_q) == '0) && ($past(fill) == '0) |-> !busy_q);
endmodule

// File: rtl/nand_pf_pack.sv
module nand_pf_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  output logic        word_vld,
  output logic [31:0] word_out,
  output logic [1:0]  held
);
  logic [1:0]  cnt_q, cnt_d;
  logic [23:0] acc_q, acc_d;
  logic        acc_en;

  always_comb begin
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    word_vld = 1'b0;
    word_out = {byte_in, acc_q};
    if (flush) begin
      cnt_d = 2'd0;
    end else if (byte_vld) begin
      if (cnt_q == 2'd3) begin
        word_vld = 1'b1;
        cnt_d    = 2'd0;
      end else begin
        acc_d[cnt_q*8 +: 8] = byte_in;
        cnt_d = cnt_q + 2'd1;
      end
    end
  end

  assign acc_en = byte_vld && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign held = cnt_q;
endmodule

// File: rtl/nand_pf_wfifo.sv
module nand_pf_wfifo #(
  parameter int WORDS = 16,
  parameter int W     = 32,
  localparam int PTR_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CNT_W = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [WORDS];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(WORDS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wp_d = bump(wp_q);
      if (pop)  rp_d = bump(rp_q);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push && !flush |-> (cnt_q < CNT_W'(WORDS)) || pop);

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
endmodule

// File: rtl/nand_prefetch_engine.sv
module nand_prefetch_engine
  import nand_pf_pkg::*;
#(
  parameter int DEPTH_BYTES = 64,
  parameter int CNT_W       = 14,
  parameter int CS_W        = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            word_avail,
  input  logic            word_pop,
  output logic [31:0]     word_data,
  output logic [CS_W-1:0] nand_cs,
  output logic            nand_rd_req,
  input  logic            nand_rd_ack,
  input  logic [7:0]      nand_rd_data
);
  localparam int WORDS  = DEPTH_BYTES / 4;
  localparam int FILL_W = $clog2(DEPTH_BYTES + 1);
  localparam int THR_W  = FILL_W;
  localparam int WCNT_W = $clog2(WORDS + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              busy, en, dir, flush, byte_take, pack_vld, pop_go;
  logic [CNT_W-1:0]  rem, total;
  logic [THR_W-1:0]  thr;
  logic [CS_W-1:0]   cs;
  logic [FILL_W-1:0] fill;
  logic [31:0]       pack_word;
  logic [1:0]        held;
  logic [WCNT_W-1:0] wcount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  nand_pf_ctrl #(
    .DEPTH_BYTES(DEPTH_BYTES), .CNT_W(CNT_W), .THR_W(THR_W), .CS_W(CS_W), .FILL_W(FILL_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .byte_take(byte_take), .fill(fill), .busy(busy), .rem(rem), .total(total),
    .thr(thr), .cs(cs), .en(en), .dir(dir), .flush(flush)
  );

  nand_pf_pack u_pack (
    .clk(clk), .rst_n(rst_sync_n), .flush(flush), .byte_vld(byte_take), .byte_in(nand_rd_data),
    .word_vld(pack_vld), .word_out(pack_word), .held(held)
  );

  nand_pf_wfifo #(.WORDS(WORDS), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_sync_n), .flush(flush), .push(pack_vld), .din(pack_word),
    .pop(pop_go), .dout(word_data), .count(wcount)
  );

  assign fill        = FILL_W'({wcount, 2'b00}) + FILL_W'(held);
  assign nand_rd_req = busy && (rem != '0) && (fill < FILL_W'(DEPTH_BYTES));
  assign byte_take   = nand_rd_req && nand_rd_ack;
  assign word_avail  = (fill >= FILL_W'(4)) && ((fill >= thr) || (rem == '0));
  assign pop_go      = word_pop && word_avail && !flush;
  assign nand_cs     = cs;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RUN: reg_rdata[0] = busy;
      A_SETUP: begin
        reg_rdata[DIR_BIT]          = dir;
        reg_rdata[EN_BIT]           = en;
        reg_rdata[THR_LSB +: THR_W] = thr;
        reg_rdata[CS_LSB +: CS_W]   = cs;
      end
      A_LEN: reg_rdata[CNT_W-1:0] = total;
      default: begin
        reg_rdata[CNT_W-1:0]          = rem;
        reg_rdata[FILL_LSB +: FILL_W] = fill;
      end
    endcase
  end

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fill <= FILL_W'(DEPTH_BYTES));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> !nand_rd_req);
endmodule

// File: tb/nand_prefetch_engine_test.sv
`timescale 1ns/1ps
module nand_prefetch_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        word_avail;
  logic        word_pop = 1'b0;
  logic [31:0] word_data;
  logic [2:0]  nand_cs;
  logic        nand_rd_req;
  logic        nand_rd_ack = 1'b0;
  logic [7:0]  nand_rd_data = '0;

  always #2.5 clk = ~clk;

  nand_prefetch_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .word_avail(word_avail), .word_pop(word_pop), .word_data(word_data),
    .nand_cs(nand_cs), .nand_rd_req(nand_rd_req), .nand_rd_ack(nand_rd_ack),
    .nand_rd_data(nand_rd_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;
  logic [31:0] expq[$];
  logic [31:0] asm_word;
  int asm_cnt = 0;
  int budget = 0;
  int nidx = 0;
  int words_got = 0;
  bit host_go = 0;
  int nand_pct = 100;
  int host_pct = 100;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: driver pushes expected words, monitor pops and compares
  task automatic step();
    nand_rd_ack = 1'b0;
    word_pop    = 1'b0;
    if (nand_rd_req && budget > 0 && ($urandom % 100) < nand_pct) begin
      logic [7:0] b;
      b = 8'((nidx * 29 + 3) & 255);
      nidx++;
      budget--;
      nand_rd_ack  = 1'b1;
      nand_rd_data = b;
      asm_word[asm_cnt*8 +: 8] = b;
      asm_cnt++;
      if (asm_cnt == 4) begin
        expq.push_back(asm_word);
        asm_cnt = 0;
      end
    end
    if (host_go && word_avail && ($urandom % 100) < host_pct) begin
      if (expq.size() == 0) check("R8 unexpected word", word_data, 32'hxxxxxxxx);
      else check("R8 word order/packing", word_data, expq.pop_front());
      words_got++;
      word_pop = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    nand_rd_ack = 1'b0;
    word_pop    = 1'b0;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic clear_sb();
    expq.delete();
    asm_cnt = 0;
    budget = 0;
    words_got = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    steps(3);

    // R1 reset state
    rd_reg(2'd0, v); check("R1 run reg", v, 32'd0);
    rd_reg(2'd3, v); check("R1 progress", v, 32'd0);
    check("R1 req", {31'd0, nand_rd_req}, 32'd0);
    check("R1 avail", {31'd0, word_avail}, 32'd0);

    // R2 setup layout
    wr_reg(2'd1, 32'h0500_1080);
    rd_reg(2'd1, v); check("R2 setup readback", v, 32'h0500_1080);
    check("R2 nand_cs", {29'd0, nand_cs}, 32'd5);

    // R3 threshold above 64 discarded
    wr_reg(2'd1, 32'h0200_4180);
    rd_reg(2'd1, v); check("R3 thr 65 rejected", v, 32'h0500_1080);

    // R4 refused starts
    wr_reg(2'd2, 32'd10); wr_reg(2'd0, 32'd1);
    rd_reg(2'd0, v); check("R4 len not mult of 4", v, 32'd0);
    wr_reg(2'd2, 32'd0); wr_reg(2'd0, 32'd1);
    rd_reg(2'd0, v); check("R4 zero len", v, 32'd0);
    wr_reg(2'd2, 32'd128);
    wr_reg(2'd1, 32'h0500_1081); wr_reg(2'd0, 32'd1);
    rd_reg(2'd0, v); check("R4 dir=1 refused", v, 32'd0);
    wr_reg(2'd1, 32'h0500_1000); wr_reg(2'd0, 32'd1);
    rd_reg(2'd0, v); check("R4 enable=0 refused", v, 32'd0);
    check("R4 idle no req", {31'd0, nand_rd_req}, 32'd0);

    // main transfer: 128 bytes, threshold 16
    wr_reg(2'd1, 32'h0500_1080);
    wr_reg(2'd0, 32'd1);
    rd_reg(2'd0, v); check("R4 start accepted", v, 32'd1);
    budget = 12; steps(20);
    rd_reg(2'd3, v); check("R6 progress 12 in", v, {1'b0, 7'd12, 10'd0, 14'd116});
    check("R9 below threshold", {31'd0, word_avail}, 32'd0);
    word_pop = 1'b1; @(posedge clk); @(negedge clk); word_pop = 1'b0;
    rd_reg(2'd3, v); check("R9 pop ignored", v, {1'b0, 7'd12, 10'd0, 14'd116});
    budget = 4; steps(10);
    check("R9 threshold reached", {31'd0, word_avail}, 32'd1);
    budget = 1000; steps(100);
    rd_reg(2'd3, v); check("R7 full stall", v, {1'b0, 7'd64, 10'd0, 14'd64});
    check("R7 req low when full", {31'd0, nand_rd_req}, 32'd0);
    wr_reg(2'd0, 32'd1);
    rd_reg(2'd3, v); check("R5 restart refused", v, {1'b0, 7'd64, 10'd0, 14'd64});
    wr_reg(2'd2, 32'd8);
    rd_reg(2'd2, v); check("R12 len write ignored", v, 32'd128);
    wr_reg(2'd1, 32'h0300_0880);
    rd_reg(2'd1, v); check("R12 setup write ignored", v, 32'h0500_1080);
    host_go = 1;
    for (int i = 0; i < 2000 && words_got < 32; i++) step();
    host_go = 0;
    check("R8 word count", 32'(words_got), 32'd32);
    rd_reg(2'd3, v); check("R10 drained", v, 32'd0);
    rd_reg(2'd0, v); check("R10 busy one more cycle", v, 32'd1);
    step();
    rd_reg(2'd0, v); check("R10 busy cleared", v, 32'd0);
    check("R8 queue empty", 32'(expq.size()), 32'd0);
    clear_sb();

    // R11 stop via run register and via setup register
    wr_reg(2'd1, 32'h0500_0480); wr_reg(2'd2, 32'd64); wr_reg(2'd0, 32'd1);
    budget = 10; steps(15);
    rd_reg(2'd3, v); check("R6 progress 10 in", v, {1'b0, 7'd10, 10'd0, 14'd54});
    check("R9 avail at thr 4", {31'd0, word_avail}, 32'd1);
    wr_reg(2'd0, 32'd0);
    rd_reg(2'd0, v); check("R11 run stop busy", v, 32'd0);
    rd_reg(2'd3, v); check("R11 run stop progress", v, 32'd0);
    check("R11 run stop req", {31'd0, nand_rd_req}, 32'd0);
    check("R11 run stop avail", {31'd0, word_avail}, 32'd0);
    clear_sb();
    wr_reg(2'd0, 32'd1);
    rd_reg(2'd0, v); check("R4 restart after stop", v, 32'd1);
    budget = 6; steps(10);
    wr_reg(2'd1, 32'd0);
    rd_reg(2'd0, v); check("R11 setup stop busy", v, 32'd0);
    rd_reg(2'd1, v); check("R11 setup cleared", v, 32'd0);
    rd_reg(2'd3, v); check("R11 setup stop progress", v, 32'd0);
    clear_sb();

    // random stalls on both sides, 20 bytes, threshold 8
    wr_reg(2'd1, 32'h0200_0880); wr_reg(2'd2, 32'd20);
    check("R2 nand_cs 2", {29'd0, nand_cs}, 32'd2);
    wr_reg(2'd0, 32'd1);
    nand_pct = 50; host_pct = 40; budget = 1000; host_go = 1;
    for (int i = 0; i < 3000; i++) begin
      rd_reg(2'd0, v);
      if (v == 32'd0) break;
      step();
    end
    host_go = 0;
    check("R10 random run finished", v, 32'd0);
    check("R8 random word count", 32'(words_got), 32'd5);
    check("R8 random queue empty", 32'(expq.size()), 32'd0);

    done_flag = 1;
    summary();
  end
endmodule